// File: doc/BRIEF.md
# IEC958 AM824 Label Generator

This block turns a stream of 16-bit PCM samples, each delivered as a pair of bytes with the low byte first, into 32-bit AM824 quadlets for a two-channel audio stream. Every accepted sample yields one quadlet one clock later. The sample sits in the middle sixteen bits of the quadlet. The top byte carries an IEC958 label that the block builds on the fly from two counters: a subframe index that alternates between the two channels, and a frame position within the 192-frame channel-status block.

The label holds four flags: block start, first subframe, parity and a channel-status bit. The channel-status bit follows a fixed pattern across the block. It marks compressed audio in one frame, and it carries a four-bit sample-rate nibble across four consecutive frames. The format and rate inputs are sampled together with each sample. When the raw format is selected, the label byte is left empty while the counters keep tracking position. Packet assembly and transmission are left to the surrounding logic.

Top module: `aml_gen`

## Requirements
- R1: In every output quadlet, bits 23:16 hold the second (high) input byte `in_bytes[15:8]`, bits 15:8 hold the first (low) byte `in_bytes[7:0]`, and bits 7:0 are zero.
- R2: Label bit 29 (label bit 5, block start) is 1 exactly when the frame position is 0 and the subframe index is 0, for non-raw formats.
- R3: The subframe index starts at 0 after reset and alternates with every accepted sample. Quadlet bit 28 (label bit 4) is 1 for subframe 0 and 0 for subframe 1, for non-raw formats.
- R4: Quadlet bit 27 (label bit 3) equals the XOR of quadlet bits 23:8 and the channel-status bit, for non-raw formats.
- R5: Quadlet bit 26 (label bit 2) is the channel-status bit. In frame 1 it is 1 when `in_fmt` is 1 (compressed audio) and 0 when `in_fmt` is 0 (PCM).
- R6: The frame position advances by one after each subframe-1 sample and wraps from 191 to 0, so block start recurs every 384 accepted samples.
- R7: In frames 24, 25, 26 and 27, the channel-status bit is bit 3, 2, 1 and 0 respectively of a rate nibble. The nibble is 0xC for `in_rate`=0 (32 kHz), 0x4 for `in_rate`=2 (48 kHz), and 0x0 for `in_rate`=1 (44.1 kHz) and for codes 3 to 7 (higher rates).
- R8: In all other frames the channel-status bit is 0. Quadlet bits 25:24 are always 0.
- R9: With `in_fmt`=2 (raw), quadlet bits 31:24 are all zero, and the counters still advance.
- R10: A synchronous reset clears the frame position and the subframe index to 0 and drives `out_valid` low.
- R11: `out_valid` rises exactly one cycle after an accepted `in_valid`. Cycles without `in_valid` neither produce output nor move the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_bytes | input | 16 | Sample bytes; [7:0] low byte, [15:8] high byte |
| in_fmt | input | 2 | 0 PCM, 1 compressed audio, 2 raw |
| in_rate | input | 3 | Sample-rate select (0 32k, 1 44.1k, 2 48k, 3..7 higher) |
| out_valid | output | 1 | Quadlet valid |
| out_quad | output | 32 | AM824 quadlet with label byte |

## Verification
On every cycle, the in-line assertions check the counter stepping and wrap, the alternation of the subframe index, and the zero label in raw mode. They also check that the parity bit agrees with the placed sample and the channel-status bit, that block start only appears on a first-subframe quadlet, and that the two low label bits stay clear. Some behaviours need a stimulus sequence to show: the channel-status pattern in frames 1 and 24 to 27 for each rate and format, the 384-sample period of block start, idle cycles that leave position untouched, and a reset in mid-stream that restarts the block. The bench's scenarios cover these.

// File: rtl/aml_pkg.sv
package aml_pkg;

    localparam int SAMPLE_W   = 16;
    localparam int QUAD_W     = 32;
    localparam int LABEL_LSB  = 24;
    localparam int SAMPLE_LSB = 8;

    typedef enum logic [1:0] {
        FMT_PCM  = 2'd0,
        FMT_COMP = 2'd1,
        FMT_RAW  = 2'd2,
        FMT_RSVD = 2'd3
    } fmt_e;

    typedef struct packed {
        logic       blk_start;
        logic       first_sub;
        logic       parity;
        logic       cs;
        logic [1:0] zero;
    } label_t;

    // Four-bit rate nibble sent MSB first over the rate frames.
    function automatic logic [3:0] rate_nibble(input logic [2:0] rate);
        case (rate)
            3'd0:    return 4'hC;
            3'd2:    return 4'h4;
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic cs_for_frame(input int frame, input fmt_e fmt,
                                          input logic [3:0] nib, input int rate_first);
        if (frame == 1)
            return (fmt == FMT_COMP);
        else if (frame >= rate_first && frame < rate_first + 4)
            return nib[3 - (frame - rate_first)];
        else
            return 1'b0;
    endfunction

endpackage

// File: rtl/aml_position.sv
module aml_position #(
    parameter int FRAMES = 192,
    localparam int FW = $clog2(FRAMES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic          sub,
    output logic [FW-1:0] frame
);
    localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sub   <= 1'b0;
            frame <= '0;
        end else if (adv) begin
            sub <= ~sub;
            if (sub)
                frame <= (frame == LAST) ? '0 : frame + 1'b1;
        end
    end

    p_frame_range_r6: assert property (@(posedge clk) disable iff (rst)
        frame <= LAST);

    p_frame_step_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && sub) |=> (frame == (($past(frame) == LAST) ? '0 : $past(frame) + 1'b1)));

    p_sub_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        adv |=> (sub != $past(sub)));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(frame) && $stable(sub)));

endmodule

// File: rtl/aml_label.sv
module aml_label
    import aml_pkg::*;
#(
    parameter int FRAMES     = 192,
    parameter int RATE_FIRST = 24,
    localparam int FW = $clog2(FRAMES)
) (
    input  logic [FW-1:0]       frame,
    input  logic                sub,
    input  fmt_e                fmt,
    input  logic [2:0]          rate,
    input  logic [SAMPLE_W-1:0] bytes_le,
    output logic [QUAD_W-1:0]   quad
);
    logic [SAMPLE_W-1:0] placed;
    logic                cs;
    label_t              lbl;

    always_comb begin
        placed = {bytes_le[15:8], bytes_le[7:0]};
        cs     = cs_for_frame(int'(frame), fmt, rate_nibble(rate), RATE_FIRST);
        if (fmt == FMT_RAW) begin
            lbl = '0;
        end else begin
            lbl.blk_start = (frame == '0) && !sub;
            lbl.first_sub = !sub;
            lbl.parity    = (^placed) ^ cs;
            lbl.cs        = cs;
            lbl.zero      = 2'b00;
        end
        quad = '0;
        quad[LABEL_LSB+7:LABEL_LSB+2] = {2'b00, lbl.blk_start, lbl.first_sub, lbl.parity, lbl.cs};
        quad[LABEL_LSB+1:LABEL_LSB]   = lbl.zero;
        quad[SAMPLE_LSB+SAMPLE_W-1:SAMPLE_LSB] = placed;
    end

endmodule

// File: rtl/aml_gen.sv
module aml_gen
    import aml_pkg::*;
#(
    parameter int FRAMES     = 192,
    parameter int RATE_FIRST = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] in_bytes,
    input  logic [1:0]  in_fmt,
    input  logic [2:0]  in_rate,
    output logic        out_valid,
    output logic [31:0] out_quad
);
    localparam int FW = $clog2(FRAMES);

    logic          sub;
    logic [FW-1:0] frame;
    logic [31:0]   quad_c;
    fmt_e          fmt;

    assign fmt = fmt_e'(in_fmt);

    aml_position #(.FRAMES(FRAMES)) u_pos (
        .clk   (clk),
        .rst   (rst),
        .adv   (in_valid),
        .sub   (sub),
        .frame (frame)
    );

    aml_label #(.FRAMES(FRAMES), .RATE_FIRST(RATE_FIRST)) u_lbl (
        .frame    (frame),
        .sub      (sub),
        .fmt      (fmt),
        .rate     (in_rate),
        .bytes_le (in_bytes),
        .quad     (quad_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_quad  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_quad <= quad_c;
        end
    end

    p_raw_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt == FMT_RAW) |=> (out_quad[31:24] == 8'h00));

    p_parity_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt != FMT_RAW) |=> (out_quad[27] == ((^out_quad[23:8]) ^ out_quad[26])));

    p_blk_first_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_quad[29]) |-> out_quad[28]);

    p_low_label_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_quad[25:24] == 2'b00 && out_quad[7:0] == 8'h00));

    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/aml_gen_tb.sv
module aml_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_bytes = '0;
    logic [1:0]  in_fmt = '0;
    logic [2:0]  in_rate = '0;
    logic        out_valid;
    logic [31:0] out_quad;

    int checks = 0;
    int fails  = 0;
    int m_sub   = 0;
    int m_frame = 0;
    bit done = 0;

    always #5 clk = ~clk;

    aml_gen u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bytes(in_bytes),
        .in_fmt(in_fmt), .in_rate(in_rate), .out_valid(out_valid), .out_quad(out_quad)
    );

    function automatic bit exp_cs(int frame, int fmt, int rate);
        bit [3:0] nib;
        nib = (rate == 0) ? 4'hC : (rate == 2) ? 4'h4 : 4'h0;
        if (frame == 1) return fmt == 1;
        if (frame >= 24 && frame <= 27) return nib[27 - frame];
        return 0;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(bit v, logic [15:0] b, int fmt, int rate);
        bit cs;
        logic [7:0] lbl;
        @(negedge clk);
        in_valid = v; in_bytes = b; in_fmt = fmt[1:0]; in_rate = rate[2:0];
        @(posedge clk);
        #1;
        check(out_valid == v, "R11 out_valid", {31'b0, out_valid}, {31'b0, v});
        if (v) begin
            cs = exp_cs(m_frame, fmt, rate);
            check(out_quad[23:0] == {b[15:8], b[7:0], 8'h00}, "R1 sample", out_quad, {8'h00, b, 8'h00});
            if (fmt == 2) begin
                check(out_quad[31:24] == 8'h00, "R9 raw label", out_quad, 32'h0);
            end else begin
                lbl = {2'b00, (m_frame == 0 && m_sub == 0), (m_sub == 0), (^b) ^ cs, cs, 2'b00};
                check(out_quad[29] == lbl[5], "R2 block start", out_quad, {lbl, 24'h0});
                check(out_quad[28] == lbl[4], "R3 subframe flag", out_quad, {lbl, 24'h0});
                check(out_quad[27] == lbl[3], "R4 parity", out_quad, {lbl, 24'h0});
                if (m_frame == 1)
                    check(out_quad[26] == cs, "R5 format status", out_quad, {lbl, 24'h0});
                else if (m_frame >= 24 && m_frame <= 27)
                    check(out_quad[26] == cs, "R7 rate status", out_quad, {lbl, 24'h0});
                else
                    check(out_quad[26] == cs, "R8 idle status", out_quad, {lbl, 24'h0});
                check(out_quad[31:24] == lbl, "R8 label byte", out_quad, {lbl, 24'h0});
            end
            if (m_sub == 1) m_frame = (m_frame == 191) ? 0 : m_frame + 1;
            m_sub = 1 - m_sub;
        end
        in_valid = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 0, "R10 reset valid", {31'b0, out_valid}, 32'h0);
        @(negedge clk); rst = 0;
        // directed: one full block at each rate with PCM and compressed
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 384; i++)
                send(1, 16'($urandom), (r == 3) ? 1 : 0, r);
        end
        // R6 wrap: after 4*384 samples, block start again at position 0
        send(1, 16'hA55A, 0, 1);
        check(out_quad[29] == 1'b1, "R6 wrap block start", out_quad, 32'h2000_0000);
        send(1, 16'h0001, 0, 1);
        // random mix with gaps and all formats
        for (int i = 0; i < 3000; i++) begin
            int f;
            f = int'($urandom % 4);
            if (f == 3) f = 0;
            send(($urandom % 4) != 0, 16'($urandom), f, int'($urandom % 8));
        end
        // R10: reset mid-stream restarts block
        send(1, 16'h1234, 0, 0);
        @(negedge clk); rst = 1;
        @(posedge clk); #1;
        check(out_valid == 0, "R10 mid reset valid", {31'b0, out_valid}, 32'h0);
        @(negedge clk); rst = 0;
        m_sub = 0; m_frame = 0;
        send(1, 16'h00FF, 1, 2);
        check(out_quad[29:28] == 2'b11, "R10 restart at block start", out_quad, 32'h3000_0000);
        for (int i = 0; i < 60; i++) send(1, 16'($urandom), 1, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule